// File: doc/BRIEF.md
# Pulse-Link Receiver with Loss-of-Link Watchdog

This block sits on the receiving side of a link that carries a level across a barrier as short pulses rather than as a level. One pulse line marks a rising level and the other marks a falling level. The block holds the last level it was told about and drives it on `data_out`. The sender repeats the current level at a steady interval even when the level does not change, so a silent link means the sender has gone away.

A watchdog counts clock edges since the last accepted pulse. If `TIMEOUT_CYCLES` edges pass with no accepted pulse, the link is declared lost. `link_ok` then drops and `data_out` is forced to a safe high level. The first accepted pulse after that restores both at once. A cycle in which both pulse lines are high carries no meaning, so the block discards it.

Top module: `pulse_link_receiver`

## Requirements
- R1: While `rst` is high, and afterwards until the first accepted pulse, `data_out` is 1 and `link_ok` is 0.
- R2: A clock edge that samples `set_pulse`=1 and `reset_pulse`=0 makes `data_out` 1 from that edge on.
- R3: A clock edge that samples `reset_pulse`=1 and `set_pulse`=0 makes `data_out` 0 from that edge on.
- R4: While `link_ok` is 1, an edge that samples both pulse lines low leaves `data_out` unchanged.
- R5: An edge that samples both pulse lines high is discarded. It changes neither the stored level nor the watchdog, so it does not delay an expiry.
- R6: Each accepted pulse (exactly one line high) restarts the watchdog. Pulses spaced at most `TIMEOUT_CYCLES` edges apart keep `link_ok` at 1.
- R7: If none of the `TIMEOUT_CYCLES` edges after an accepted pulse samples an accepted pulse, `link_ok` falls on the last of those edges, and not earlier.
- R8: While `link_ok` is 0, `data_out` is 1 whatever level was last stored.
- R9: The edge that samples the first accepted pulse after an expiry, or after reset, sets `link_ok` to 1 and sets `data_out` to that pulse's level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse | input | 1 | One-cycle request to drive the output high |
| reset_pulse | input | 1 | One-cycle request to drive the output low |
| data_out | output | 1 | Stored level, or forced 1 while the link is lost |
| link_ok | output | 1 | 1 while the watchdog has not expired |

## Verification
The properties treat each cycle in which a pulse line is high as one separate pulse. They make no assumption about pulse width or spacing, because a line held high for several cycles simply counts as repeated pulses. The stimulus drives the pulse lines for exactly one cycle at a time, always changing them on the falling clock edge. Idle gaps are placed at the timeout minus one, at the timeout exactly, and beyond it, so that the expiry edge is reached from both sides. Simultaneous pulses are applied both with the link up and with the link lost, so that the discard rule is checked in both watchdog states.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;

    // Classified pulse event for one sampled clock edge
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_SET   = 2'd1,
        EV_CLR   = 2'd2,
        EV_CLASH = 2'd3
    } pulse_ev_e;

    function automatic logic ev_is_accepted(input pulse_ev_e ev);
        return (ev == EV_SET) || (ev == EV_CLR);
    endfunction

endpackage

// File: rtl/pulse_event_decoder.sv
module pulse_event_decoder
    import pulse_link_pkg::*;
(
    input  logic      set_pulse,
    input  logic      reset_pulse,
    output pulse_ev_e ev,
    output logic      accepted
);

    always_comb begin
        unique case ({reset_pulse, set_pulse})
            2'b01:   ev = EV_SET;
            2'b10:   ev = EV_CLR;
            2'b11:   ev = EV_CLASH;
            default: ev = EV_IDLE;
        endcase
        accepted = ev_is_accepted(ev);
    end

endmodule

// File: rtl/level_holder.sv
module level_holder
    import pulse_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pulse_ev_e ev,
    output logic      level
);

    typedef struct packed {
        logic level;
    } hold_state_t;

    hold_state_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        case (ev)
            EV_SET:  hold_d.level = 1'b1;
            EV_CLR:  hold_d.level = 1'b0;
            default: hold_d.level = hold_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '{level: 1'b1};
        else     hold_q <= hold_d;
    end

    assign level = hold_q.level;

endmodule

// File: rtl/link_watchdog.sv
module link_watchdog #(
    parameter int TIMEOUT_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expired
);

    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } wd_state_t;

    wd_state_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (kick) begin
            wd_d.cnt     = '0;
            wd_d.expired = 1'b0;
        end else if (!wd_q.expired) begin
            if (wd_q.cnt == LIMIT) wd_d.expired = 1'b1;
            else                   wd_d.cnt     = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wd_q <= '{cnt: '0, expired: 1'b1};
        else     wd_q <= wd_d;
    end

    assign expired = wd_q.expired;

    // R7
    expiry_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_q.expired) |-> ($past(wd_q.cnt) == LIMIT));

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        wd_q.cnt <= LIMIT);

endmodule

// File: rtl/pulse_link_receiver.sv
module pulse_link_receiver
    import pulse_link_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic reset_pulse,
    output logic data_out,
    output logic link_ok
);

    pulse_ev_e ev;
    logic      accepted;
    logic      level;
    logic      expired;

    pulse_event_decoder u_dec (
        .set_pulse   (set_pulse),
        .reset_pulse (reset_pulse),
        .ev          (ev),
        .accepted    (accepted)
    );

    level_holder u_hold (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .level (level)
    );

    link_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .kick    (accepted),
        .expired (expired)
    );

    assign data_out = level | expired;
    assign link_ok  = ~expired;

    // R2
    set_high_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && !reset_pulse) |=> data_out);

    // R3
    clr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reset_pulse && !set_pulse) |=> !data_out);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_pulse && !reset_pulse && link_ok) |=> (!link_ok || $stable(data_out)));

    // R5
    clash_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && reset_pulse && !link_ok) |=> (!link_ok && data_out));

    // R6
    pulse_revives_chk: assert property (@(posedge clk) disable iff (rst)
        (set_pulse != reset_pulse) |=> link_ok);

    // R8
    forced_high_chk: assert property (@(posedge clk) disable iff (rst)
        !link_ok |-> data_out);

endmodule

// File: tb/pulse_link_receiver_test.sv
module pulse_link_receiver_test;

    localparam int TMO = 40;

    typedef struct {
        bit    d;
        bit    ok;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_pulse = 1'b0;
    logic reset_pulse = 1'b0;
    logic data_out;
    logic link_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t sb[$];

    // reference state derived from the requirements
    bit m_lvl = 1'b1;
    bit m_exp = 1'b1;
    int m_cnt = 0;

    always #2 clk = ~clk;

    pulse_link_receiver #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk         (clk),
        .rst         (rst),
        .set_pulse   (set_pulse),
        .reset_pulse (reset_pulse),
        .data_out    (data_out),
        .link_ok     (link_ok)
    );

    task automatic compare(input bit d, input bit ok, input string tag);
        checks++;
        if (data_out !== d || link_ok !== ok) begin
            errors++;
            $display("FAIL %s: data_out=%b link_ok=%b expected data_out=%b link_ok=%b at %0t",
                     tag, data_out, link_ok, d, ok, $time);
        end
    endtask

    // driver: one edge of stimulus, expected result queued
    task automatic step(input bit s, input bit r, input string tag);
        exp_t e;
        @(negedge clk);
        set_pulse   = s;
        reset_pulse = r;
        if (s != r) begin
            m_lvl = s;
            m_exp = 1'b0;
            m_cnt = 0;
        end else if (!m_exp) begin
            if (m_cnt == TMO - 1) m_exp = 1'b1;
            else                  m_cnt++;
        end
        e.d   = m_lvl | m_exp;
        e.ok  = !m_exp;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
    endtask

    // monitor: sample just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.d, e.ok, e.tag);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare(1'b1, 1'b0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare(1'b1, 1'b0, "R1 after reset release");

        idle(5, "R1 idle before first pulse");
        step(1'b1, 1'b1, "R5 clash with link lost");
        idle(2, "R5 after clash");

        step(1'b0, 1'b1, "R9 first pulse after reset is clear");
        idle(10, "R4 hold low");
        step(1'b1, 1'b0, "R2 set pulse");
        idle(3, "R4 hold high");
        step(1'b0, 1'b1, "R3 clear pulse");

        for (int k = 0; k < 5; k++) begin
            idle(TMO - 1, "R6 gap just under timeout");
            step(1'b0, 1'b1, "R6 refresh clear");
        end
        idle(TMO - 1, "R6 gap before set");
        step(1'b1, 1'b0, "R6 refresh set");

        step(1'b0, 1'b1, "R3 clear before clash");
        idle(TMO - 3, "R5 idle before clash");
        step(1'b1, 1'b1, "R5 clash does not restart watchdog");
        idle(1, "R7 edge before expiry");
        idle(1, "R7 expiry edge");
        idle(10, "R8 forced high with stored low");

        step(1'b1, 1'b0, "R9 recovery with set");
        step(1'b0, 1'b1, "R3 clear after recovery");
        idle(TMO, "R7 exact timeout gap");
        step(1'b1, 1'b1, "R5 clash while lost");
        step(1'b0, 1'b1, "R9 recovery with clear");
        idle(TMO - 1, "R6 gap under timeout");
        step(1'b1, 1'b0, "R6 last-edge refresh");
        idle(TMO + 5, "R8 expiry after set");

        step(1'b0, 1'b0, "R8 tail");
        @(posedge clk);
        #2;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard left %0d items, expected 0", sb.size());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog expired: finished=0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule